// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column address, one per clock, for a single SDRAM read or write burst. A start pulse loads a column, a burst length code, an ordering choice and an auto-precharge flag. From the next cycle the block presents one column per clock, with a valid strobe, until the burst ends. A fixed-length burst ends on its own. A full-page burst runs until a terminate pulse or another command pulse stops it.

The columns follow either a sequential order, which wraps inside the aligned block, or an interleaved order, which is the start column XOR the beat count. A new start pulse may arrive on any clock and takes over from whatever burst is running. When a fixed-length burst runs to its end with auto-precharge enabled, the block raises a one-cycle precharge request. Data, byte masks and command decode belong to neighbouring blocks.

Top module: `burst_col_seq`

## Requirements
- R1: A synchronous active-high reset drives `beat_vld_o`, `last_o`, `ap_req_o` and `col_o` to zero from the cycle after the reset edge, and it aborts any burst in progress.
- R2: In the cycle after a clock edge with `start_i` high, `beat_vld_o` is 1 and `col_o` equals the `start_col_i` sampled at that edge.
- R3: The length code `blen_i` selects the burst size. 0 gives 1 beat, 1 gives 2 beats, 2 gives 4 beats and 3 gives 8 beats. 7 gives a full-page burst. Codes 4, 5 and 6 give 1 beat.
- R4: With `btype_i`=0 (sequential), beat k presents (start & ~(L-1)) | ((start + k) & (L-1)), where L is the burst length. The burst therefore wraps inside the aligned block of L columns.
- R5: With `btype_i`=1 (interleaved), beat k of a fixed-length burst presents start XOR k.
- R6: A full-page burst is always sequential, whatever the value of `btype_i`. Its column wraps from 255 to 0, and it continues until it is ended by R8, R9 or R10. During a full-page burst `last_o` stays low.
- R7: `last_o` is high exactly on the final beat of a fixed-length burst. In the cycle after that final beat, `beat_vld_o` is low unless a new burst has started.
- R8: A `start_i` pulse during a running burst replaces that burst, and the new beat 0 appears in the next cycle. `start_i` takes priority over `term_i` and `intr_i` at the same edge.
- R9: `term_i` high at an edge (without `start_i`) ends the burst. `beat_vld_o` is low in the next cycle.
- R10: `intr_i` high at an edge (without `start_i`), standing for any other command, also ends the burst. `beat_vld_o` is low in the next cycle.
- R11: `ap_req_o` is high for exactly one cycle: the cycle after the final beat of a fixed-length burst that was started with `ap_en_i`=1. It is never raised for a full-page burst, nor for a burst cut short by R8, R9, R10 or R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start a new burst with the fields below |
| start_col_i | input | 8 | Start column |
| blen_i | input | 3 | Burst length code (R3) |
| btype_i | input | 1 | 0 sequential, 1 interleaved |
| ap_en_i | input | 1 | Request auto-precharge on completion |
| term_i | input | 1 | Terminate the running burst |
| intr_i | input | 1 | Another command ends the running burst |
| col_o | output | 8 | Column of the current beat |
| beat_vld_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | Final beat of a fixed-length burst |
| ap_req_o | output | 1 | One-cycle auto-precharge request |

## Verification
Every output is registered, so each result appears one cycle after the clock edge that captures its cause:
- beat 0 appears one cycle after the start edge, and each later beat one cycle after the one before;
- the valid strobe drops one cycle after a terminate or interrupt edge;
- the precharge request appears in the cycle that follows the last beat.

The bench changes inputs on the falling edge and samples outputs on the next falling edge. Each check therefore falls half a period after the rising edge that should have produced the value. The bench counts beats itself, so each expected column is tied to a known beat index.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  // Length code for a full-page burst; codes 0..FIX_CODES-1 are 2**code beats.
  localparam logic [2:0] BL_FULL   = 3'd7;
  localparam int         FIX_CODES = 4;
  localparam int         BL_W      = 3;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_XOR = 1'b1
  } order_e;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode import burst_seq_pkg::*; #(
  parameter int COL_W = 8
) (
  input  logic [BL_W-1:0]  code_i,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o
);
  always_comb begin
    full_o = (code_i == BL_FULL);
    mask_o = '0;
    if (full_o) begin
      mask_o = '1;
    end else begin
      for (int c = 1; c < FIX_CODES; c++) begin
        if (int'(code_i) == c) mask_o = COL_W'((1 << c) - 1);
      end
    end
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen import burst_seq_pkg::*; #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] idx_i,
  input  logic [COL_W-1:0] mask_i,
  input  order_e           order_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] low_part;

  always_comb begin
    if (order_i == ORD_XOR) low_part = (base_i ^ idx_i) & mask_i;
    else                    low_part = (base_i + idx_i) & mask_i;
    col_o = (base_i & ~mask_i) | low_part;
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq import burst_seq_pkg::*; #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [BL_W-1:0]  blen_i,
  input  logic             btype_i,
  input  logic             ap_en_i,
  input  logic             term_i,
  input  logic             intr_i,
  output logic [COL_W-1:0] col_o,
  output logic             beat_vld_o,
  output logic             last_o,
  output logic             ap_req_o
);
  logic [COL_W-1:0] base_q, base_d, idx_q, idx_d, mask_q, mask_d;
  logic             itl_q, itl_d, full_q, full_d, ap_en_q, ap_en_d;
  logic             vld_q, vld_d, last_q, last_d, apr_q;
  logic [COL_W-1:0] col_q, col_d, dec_mask;
  logic             dec_full;
  order_e           order_d;

  burst_len_decode #(.COL_W(COL_W)) u_dec (
    .code_i (blen_i),
    .mask_o (dec_mask),
    .full_o (dec_full)
  );

  // Next-state: start wins, then terminate/interrupt, then normal advance.
  always_comb begin
    base_d  = base_q;
    idx_d   = idx_q;
    mask_d  = mask_q;
    itl_d   = itl_q;
    full_d  = full_q;
    ap_en_d = ap_en_q;
    vld_d   = vld_q;
    if (start_i) begin
      vld_d   = 1'b1;
      idx_d   = '0;
      base_d  = start_col_i;
      mask_d  = dec_mask;
      full_d  = dec_full;
      itl_d   = btype_i & ~dec_full;
      ap_en_d = ap_en_i & ~dec_full;
    end else if (term_i || intr_i) begin
      vld_d = 1'b0;
    end else if (vld_q) begin
      if (last_q) vld_d = 1'b0;
      else        idx_d = idx_q + 1'b1;
    end
  end

  assign order_d = itl_d ? ORD_XOR : ORD_SEQ;

  burst_col_gen #(.COL_W(COL_W)) u_gen (
    .base_i  (base_d),
    .idx_i   (idx_d),
    .mask_i  (mask_d),
    .order_i (order_d),
    .col_o   (col_d)
  );

  assign last_d = vld_d && !full_d && (idx_d == mask_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q  <= '0;
      idx_q   <= '0;
      mask_q  <= '0;
      itl_q   <= 1'b0;
      full_q  <= 1'b0;
      ap_en_q <= 1'b0;
      vld_q   <= 1'b0;
      last_q  <= 1'b0;
      col_q   <= '0;
      apr_q   <= 1'b0;
    end else begin
      base_q  <= base_d;
      idx_q   <= idx_d;
      mask_q  <= mask_d;
      itl_q   <= itl_d;
      full_q  <= full_d;
      ap_en_q <= ap_en_d;
      vld_q   <= vld_d;
      last_q  <= last_d;
      col_q   <= col_d;
      apr_q   <= vld_q && last_q && ap_en_q;
    end
  end

  assign col_o      = col_q;
  assign beat_vld_o = vld_q;
  assign last_o     = last_q;
  assign ap_req_o   = apr_q;

  p_start_beat_r2: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (beat_vld_o && col_o == $past(start_col_i)));

  p_full_no_last_r6: assert property (@(posedge clk) disable iff (rst)
    (beat_vld_o && full_q) |-> !last_o);

  p_last_in_beat_r7: assert property (@(posedge clk) disable iff (rst)
    last_o |-> beat_vld_o);

  p_last_ends_r7: assert property (@(posedge clk) disable iff (rst)
    (last_o && !start_i) |=> !beat_vld_o);

  p_term_stops_r9: assert property (@(posedge clk) disable iff (rst)
    (term_i && !start_i) |=> !beat_vld_o);

  p_intr_stops_r10: assert property (@(posedge clk) disable iff (rst)
    (intr_i && !start_i) |=> !beat_vld_o);

  p_ap_after_last_r11: assert property (@(posedge clk) disable iff (rst)
    ap_req_o |-> ($past(last_o) && $past(beat_vld_o)));

  p_ap_single_r11: assert property (@(posedge clk) disable iff (rst)
    ap_req_o |=> !ap_req_o);
endmodule

// File: tb/burst_col_seq_test.sv
`timescale 1ns/1ps
module burst_col_seq_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0, btype_i = 1'b0, ap_en_i = 1'b0;
  logic       term_i = 1'b0, intr_i = 1'b0;
  logic [7:0] start_col_i = '0;
  logic [2:0] blen_i = '0;
  logic [7:0] col_o;
  logic       beat_vld_o, last_o, ap_req_o;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  burst_col_seq uut (
    .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
    .blen_i(blen_i), .btype_i(btype_i), .ap_en_i(ap_en_i), .term_i(term_i),
    .intr_i(intr_i), .col_o(col_o), .beat_vld_o(beat_vld_o), .last_o(last_o),
    .ap_req_o(ap_req_o)
  );

  // Fields: col[80:73] blen[72:70] itl[69] ap[68] beats[67:64] cols[63:0]
  localparam logic [80:0] VEC [9] = '{
    {8'h05, 3'd2, 1'b0, 1'b1, 4'd4, 64'h05060704_00000000},
    {8'h05, 3'd2, 1'b1, 1'b0, 4'd4, 64'h05040706_00000000},
    {8'h0D, 3'd3, 1'b0, 1'b0, 4'd8, 64'h0D0E0F08_090A0B0C},
    {8'h0D, 3'd3, 1'b1, 1'b1, 4'd8, 64'h0D0C0F0E_09080B0A},
    {8'h23, 3'd1, 1'b0, 1'b1, 4'd2, 64'h23220000_00000000},
    {8'h23, 3'd1, 1'b1, 1'b0, 4'd2, 64'h23220000_00000000},
    {8'h7F, 3'd0, 1'b0, 1'b1, 4'd1, 64'h7F000000_00000000},
    {8'hFE, 3'd3, 1'b0, 1'b0, 4'd8, 64'hFEFFF8F9_FAFBFCFD},
    {8'h33, 3'd5, 1'b1, 1'b1, 4'd1, 64'h33000000_00000000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a falling edge; returns one falling edge later with beat 0 shown.
  task automatic go(input logic [7:0] c, input logic [2:0] bl, input logic it, input logic ap);
    start_i = 1'b1; start_col_i = c; blen_i = bl; btype_i = it; ap_en_i = ap;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung, expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 vld", 32'(beat_vld_o), 0);
    chk("R1 last", 32'(last_o), 0);
    chk("R1 ap", 32'(ap_req_o), 0);
    chk("R1 col", 32'(col_o), 0);
    rst = 1'b0;
    @(negedge clk);

    // Vector table: R2 R3 R4 R5 R7 R11
    foreach (VEC[i]) begin
      go(VEC[i][80:73], VEC[i][72:70], VEC[i][69], VEC[i][68]);
      for (int j = 0; j < int'(VEC[i][67:64]); j++) begin
        if (j > 0) @(negedge clk);
        chk(j == 0 ? "R2 vld" : "R3 vld", 32'(beat_vld_o), 1);
        chk(VEC[i][69] ? "R5 col" : "R4 col", 32'(col_o), 32'(VEC[i][63-8*j -: 8]));
        chk("R7 last", 32'(last_o), 32'(j == int'(VEC[i][67:64]) - 1));
      end
      @(negedge clk);
      chk("R3 end", 32'(beat_vld_o), 0);
      chk("R11 ap", 32'(ap_req_o), 32'(VEC[i][68]));
      @(negedge clk);
      chk("R11 once", 32'(ap_req_o), 0);
    end

    // R6 full page, interleave ignored, wrap, no last, no ap on terminate
    go(8'hFC, 3'd7, 1'b1, 1'b1);
    for (int j = 0; j < 260; j++) begin
      if (j > 0) @(negedge clk);
      chk("R6 col", 32'(col_o), 32'(8'(8'hFC + j)));
      chk("R6 last", 32'(last_o), 0);
    end
    term_i = 1'b1;
    @(negedge clk);
    term_i = 1'b0;
    chk("R9 full", 32'(beat_vld_o), 0);
    chk("R11 full", 32'(ap_req_o), 0);
    @(negedge clk);
    chk("R11 full2", 32'(ap_req_o), 0);

    // R9 terminate a fixed burst with ap requested
    go(8'h10, 3'd3, 1'b0, 1'b1);
    @(negedge clk);
    chk("R9 beat1", 32'(col_o), 32'h11);
    term_i = 1'b1;
    @(negedge clk);
    term_i = 1'b0;
    chk("R9 stop", 32'(beat_vld_o), 0);
    chk("R11 term", 32'(ap_req_o), 0);
    repeat (8) @(negedge clk);
    chk("R11 term late", 32'(ap_req_o), 0);

    // R10 interrupt
    go(8'h44, 3'd2, 1'b1, 1'b1);
    intr_i = 1'b1;
    @(negedge clk);
    intr_i = 1'b0;
    chk("R10 stop", 32'(beat_vld_o), 0);
    chk("R11 intr", 32'(ap_req_o), 0);
    repeat (4) @(negedge clk);
    chk("R11 intr late", 32'(ap_req_o), 0);

    // R8 restart mid-burst, with terminate at the same edge
    go(8'h20, 3'd2, 1'b0, 1'b1);
    @(negedge clk);
    chk("R8 old beat1", 32'(col_o), 32'h21);
    term_i = 1'b1;
    go(8'h40, 3'd1, 1'b1, 1'b0);
    term_i = 1'b0;
    chk("R8 vld", 32'(beat_vld_o), 1);
    chk("R8 col0", 32'(col_o), 32'h40);
    @(negedge clk);
    chk("R8 col1", 32'(col_o), 32'h41);
    chk("R8 last", 32'(last_o), 1);
    @(negedge clk);
    chk("R8 end", 32'(beat_vld_o), 0);
    chk("R11 replaced", 32'(ap_req_o), 0);

    // R1 reset mid-burst
    go(8'h80, 3'd3, 1'b0, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 abort", 32'(beat_vld_o), 0);
    rst = 1'b0;
    repeat (9) @(negedge clk);
    chk("R1 no ap", 32'(ap_req_o), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule